// File: doc/BRIEF.md
# Single-Bus Accumulator Register Datapath

This block holds the working registers of a small 8-bit accumulator processor and the one shared internal bus that moves bytes between them. It contains the accumulator, a general data/pointer register, the instruction pointer, an operand-address register, the external address register, separate capture and drive registers for the external data bus, and the instruction register. A microcode sequencer outside the block supplies a control word each clock. The word enables at most one bus source and any set of register loads. The arithmetic unit also sits outside: it sees the accumulator on a dedicated port and the internal bus on a second port, and it returns its result on an input port.

Only the arithmetic result can load the accumulator, and only the instruction pointer or the operand register can load the address register. Register-indirect access therefore takes two transfers: the pointer register moves to the operand register, and then the operand register moves to the address register. The external data output is presented only while a write strobe is raised.

Top module: `acc_dp_top`

## Requirements
- R1: While reset is asserted and after its release, every register reads 00h: accumulator, pointer register, instruction pointer, address register, instruction register and both data registers. The bus reads 00h and the data output is idle.
- R2: The bus source select is one-hot, with bit0 = accumulator, bit1 = pointer register, bit2 = instruction pointer, bit3 = operand register and bit4 = captured input data. The selected register appears on `busOut` in the same cycle. With no bit set, the bus reads 00h.
- R3: `accOut` always shows the accumulator, whatever source the bus select names.
- R4: With `loadAcc` high, the accumulator takes `aluResult` at the clock edge. With it low, the accumulator holds, even if `aluResult` changes.
- R5: The pointer, operand, data-out, instruction-pointer and instruction registers load from the bus when their load strobe is high. `rMon` always shows the pointer register.
- R6: With `loadAr` high, the address register takes the instruction pointer when `arFromOpnd` is 0 and the operand register when it is 1. At all other times it holds its value on `extAddr`.
- R7: The instruction pointer gives clear priority over load, and load priority over increment. An increment from FFh wraps to 00h.
- R8: `irClr` forces the instruction register to 00h and wins over a simultaneous load.
- R9: The input data register captures `extDataIn` only while `loadDin` is high. A change on `extDataIn` without the strobe has no effect.
- R10: `extDataOut` equals the data-out register and `extDataOe` is 1 while `memWr` or `ioWr` is high. Otherwise `extDataOut` reads 00h and `extDataOe` is 0.
- R11: An indirect address takes one transfer each way: pointer register to operand register, then operand register to address register. After the second edge, `extAddr` carries the pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 5 | One-hot bus source select |
| loadAcc | input | 1 | Accumulator takes ALU result |
| loadR | input | 1 | Pointer register loads from bus |
| loadIp | input | 1 | Instruction pointer loads from bus |
| loadOpnd | input | 1 | Operand register loads from bus |
| loadDout | input | 1 | Data-out register loads from bus |
| loadIr | input | 1 | Instruction register loads from bus |
| loadDin | input | 1 | Input data register captures external data |
| loadAr | input | 1 | Address register load |
| arFromOpnd | input | 1 | Address source: 0 instruction pointer, 1 operand register |
| ipInc | input | 1 | Instruction pointer increment |
| ipClr | input | 1 | Instruction pointer clear |
| irClr | input | 1 | Instruction register clear |
| memWr | input | 1 | Memory write strobe |
| ioWr | input | 1 | Port write strobe |
| aluResult | input | 8 | Result from the arithmetic unit |
| extDataIn | input | 8 | External data bus, inbound |
| accOut | output | 8 | Accumulator, fixed ALU operand |
| busOut | output | 8 | Internal bus, second ALU operand |
| rMon | output | 8 | Pointer register monitor |
| irOut | output | 8 | Instruction register to the sequencer |
| extAddr | output | 8 | External address bus |
| extDataOut | output | 8 | External data bus, outbound |
| extDataOe | output | 1 | Outbound data valid |

## Verification
The hardest states to reach are the ones no single port can set: an address register that holds an operand-register value which itself came from the pointer register, and an instruction pointer sitting at FFh just before an increment. The stimulus reaches both by routing bytes through the captured-input register. It loads arbitrary values onto the bus, copies them through the chain of registers, and only then applies the increment, the clear-versus-load and the indirect transfer. Each result is read back by selecting the register onto the bus or watching the address output.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

  localparam int NUM_SRC = 5;
  localparam int SRC_ACC  = 0;
  localparam int SRC_RREG = 1;
  localparam int SRC_IP   = 2;
  localparam int SRC_OPND = 3;
  localparam int SRC_DIN  = 4;

  typedef enum logic [1:0] {
    IP_HOLD = 2'd0,
    IP_CLR  = 2'd1,
    IP_LOAD = 2'd2,
    IP_INC  = 2'd3
  } ipOp_t;

  typedef struct packed {
    logic  ldAcc;
    logic  ldR;
    logic  ldOpnd;
    logic  ldDout;
    logic  ldDin;
    logic  ldAr;
    logic  arFromOpnd;
    ipOp_t ipOp;
    logic  irClear;
    logic  irLoad;
    logic  extWrite;
  } dpStrobes_t;

endpackage

// File: rtl/acc_dp_ctrl.sv
module acc_dp_ctrl
  import acc_dp_pkg::*;
(
  input  logic       loadAcc,
  input  logic       loadR,
  input  logic       loadIp,
  input  logic       loadOpnd,
  input  logic       loadDout,
  input  logic       loadIr,
  input  logic       loadDin,
  input  logic       loadAr,
  input  logic       arFromOpnd,
  input  logic       ipInc,
  input  logic       ipClr,
  input  logic       irClr,
  input  logic       memWr,
  input  logic       ioWr,
  output dpStrobes_t stb
);

  always_comb begin
    stb.ldAcc      = loadAcc;
    stb.ldR        = loadR;
    stb.ldOpnd     = loadOpnd;
    stb.ldDout     = loadDout;
    stb.ldDin      = loadDin;
    stb.ldAr       = loadAr;
    stb.arFromOpnd = arFromOpnd;
    // clear beats load, load beats increment
    if (ipClr)       stb.ipOp = IP_CLR;
    else if (loadIp) stb.ipOp = IP_LOAD;
    else if (ipInc)  stb.ipOp = IP_INC;
    else             stb.ipOp = IP_HOLD;
    stb.irClear  = irClr;
    stb.irLoad   = loadIr & ~irClr;
    stb.extWrite = memWr | ioWr;
  end

endmodule

// File: rtl/acc_dp_bus.sv
module acc_dp_bus #(
  parameter int DATA_W = 8,
  parameter int N_SRC  = 5
) (
  input  logic [N_SRC-1:0]        srcEn,
  input  logic [N_SRC*DATA_W-1:0] srcFlat,
  output logic [DATA_W-1:0]       busVal
);

  logic [DATA_W-1:0] gated [N_SRC];

  for (genvar s = 0; s < N_SRC; s++) begin : g_drv
    assign gated[s] = srcFlat[s*DATA_W +: DATA_W] & {DATA_W{srcEn[s]}};
  end

  always_comb begin
    busVal = '0;
    for (int s = 0; s < N_SRC; s++) busVal = busVal | gated[s];
  end

endmodule

// File: rtl/acc_dp_regs.sv
module acc_dp_regs
  import acc_dp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        stb,
  input  logic [DATA_W-1:0] busVal,
  input  logic [DATA_W-1:0] aluResult,
  input  logic [DATA_W-1:0] extDataIn,
  output logic [DATA_W-1:0] accVal,
  output logic [DATA_W-1:0] rVal,
  output logic [DATA_W-1:0] ipVal,
  output logic [DATA_W-1:0] opndVal,
  output logic [DATA_W-1:0] arVal,
  output logic [DATA_W-1:0] dinVal,
  output logic [DATA_W-1:0] doutVal,
  output logic [DATA_W-1:0] irVal
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accVal  <= '0;
      rVal    <= '0;
      opndVal <= '0;
      doutVal <= '0;
      dinVal  <= '0;
    end else begin
      if (stb.ldAcc)  accVal  <= aluResult;
      if (stb.ldR)    rVal    <= busVal;
      if (stb.ldOpnd) opndVal <= busVal;
      if (stb.ldDout) doutVal <= busVal;
      if (stb.ldDin)  dinVal  <= extDataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ipVal <= '0;
    end else begin
      unique case (stb.ipOp)
        IP_CLR:  ipVal <= '0;
        IP_LOAD: ipVal <= busVal;
        IP_INC:  ipVal <= ipVal + ONE;
        default: ipVal <= ipVal;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) arVal <= '0;
    else if (stb.ldAr) arVal <= stb.arFromOpnd ? opndVal : ipVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irVal <= '0;
    else if (stb.irClear) irVal <= '0;
    else if (stb.irLoad) irVal <= busVal;
  end

endmodule

// File: rtl/acc_dp_top.sv
module acc_dp_top
  import acc_dp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] busSel,
  input  logic               loadAcc,
  input  logic               loadR,
  input  logic               loadIp,
  input  logic               loadOpnd,
  input  logic               loadDout,
  input  logic               loadIr,
  input  logic               loadDin,
  input  logic               loadAr,
  input  logic               arFromOpnd,
  input  logic               ipInc,
  input  logic               ipClr,
  input  logic               irClr,
  input  logic               memWr,
  input  logic               ioWr,
  input  logic [DATA_W-1:0]  aluResult,
  input  logic [DATA_W-1:0]  extDataIn,
  output logic [DATA_W-1:0]  accOut,
  output logic [DATA_W-1:0]  busOut,
  output logic [DATA_W-1:0]  rMon,
  output logic [DATA_W-1:0]  irOut,
  output logic [DATA_W-1:0]  extAddr,
  output logic [DATA_W-1:0]  extDataOut,
  output logic               extDataOe
);

  dpStrobes_t stb;
  logic [DATA_W-1:0] accVal, rVal, ipVal, opndVal, arVal, dinVal, doutVal, irVal;
  logic [DATA_W-1:0] busVal;
  logic [NUM_SRC*DATA_W-1:0] srcFlat;

  acc_dp_ctrl u_ctrl (
    .loadAcc(loadAcc), .loadR(loadR), .loadIp(loadIp), .loadOpnd(loadOpnd),
    .loadDout(loadDout), .loadIr(loadIr), .loadDin(loadDin), .loadAr(loadAr),
    .arFromOpnd(arFromOpnd), .ipInc(ipInc), .ipClr(ipClr), .irClr(irClr),
    .memWr(memWr), .ioWr(ioWr), .stb(stb)
  );

  assign srcFlat[SRC_ACC*DATA_W  +: DATA_W] = accVal;
  assign srcFlat[SRC_RREG*DATA_W +: DATA_W] = rVal;
  assign srcFlat[SRC_IP*DATA_W   +: DATA_W] = ipVal;
  assign srcFlat[SRC_OPND*DATA_W +: DATA_W] = opndVal;
  assign srcFlat[SRC_DIN*DATA_W  +: DATA_W] = dinVal;

  acc_dp_bus #(.DATA_W(DATA_W), .N_SRC(NUM_SRC)) u_bus (
    .srcEn(busSel), .srcFlat(srcFlat), .busVal(busVal)
  );

  acc_dp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .busVal(busVal),
    .aluResult(aluResult), .extDataIn(extDataIn),
    .accVal(accVal), .rVal(rVal), .ipVal(ipVal), .opndVal(opndVal),
    .arVal(arVal), .dinVal(dinVal), .doutVal(doutVal), .irVal(irVal)
  );

  assign accOut     = accVal;
  assign busOut     = busVal;
  assign rMon       = rVal;
  assign irOut      = irVal;
  assign extAddr    = arVal;
  assign extDataOe  = stb.extWrite;
  assign extDataOut = stb.extWrite ? doutVal : '0;

endmodule

// File: rtl/acc_dp_chk.sv
module acc_dp_chk #(
  parameter int DATA_W = 8,
  parameter int N_SRC  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [N_SRC-1:0]  busSel,
  input logic              loadAcc,
  input logic [DATA_W-1:0] aluResult,
  input logic [DATA_W-1:0] accOut,
  input logic              loadAr,
  input logic              arFromOpnd,
  input logic [DATA_W-1:0] ipVal,
  input logic [DATA_W-1:0] opndVal,
  input logic [DATA_W-1:0] extAddr,
  input logic              ipInc,
  input logic              ipClr,
  input logic              loadIp,
  input logic              irClr,
  input logic [DATA_W-1:0] irOut,
  input logic              memWr,
  input logic              ioWr,
  input logic [DATA_W-1:0] extDataOut
);

  // R2
  single_driver_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busSel));

  // R4
  acc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadAcc |=> accOut == $past(aluResult));

  // R4
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadAcc |=> $stable(accOut));

  // R6
  ar_from_ip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadAr && !arFromOpnd) |=> extAddr == $past(ipVal));

  // R6
  ar_from_opnd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadAr && arFromOpnd) |=> extAddr == $past(opndVal));

  // R7
  ip_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ipInc && !ipClr && !loadIp) |=> ipVal == DATA_W'($past(ipVal) + 1));

  // R8
  ir_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    irClr |=> irOut == '0);

  // R10
  dout_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWr || ioWr) |-> extDataOut == '0);

endmodule

bind acc_dp_top acc_dp_chk #(.DATA_W(DATA_W), .N_SRC(acc_dp_pkg::NUM_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .loadAcc(loadAcc),
  .aluResult(aluResult), .accOut(accOut), .loadAr(loadAr),
  .arFromOpnd(arFromOpnd), .ipVal(ipVal), .opndVal(opndVal),
  .extAddr(extAddr), .ipInc(ipInc), .ipClr(ipClr), .loadIp(loadIp),
  .irClr(irClr), .irOut(irOut), .memWr(memWr), .ioWr(ioWr),
  .extDataOut(extDataOut)
);

// File: tb/sim_acc_dp_top.sv
module sim_acc_dp_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] busSel = '0;
  logic loadAcc = 0, loadR = 0, loadIp = 0, loadOpnd = 0, loadDout = 0;
  logic loadIr = 0, loadDin = 0, loadAr = 0, arFromOpnd = 0;
  logic ipInc = 0, ipClr = 0, irClr = 0, memWr = 0, ioWr = 0;
  logic [7:0] aluResult = '0, extDataIn = '0;
  logic [7:0] accOut, busOut, rMon, irOut, extAddr, extDataOut;
  logic extDataOe;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  acc_dp_top u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .loadAcc(loadAcc), .loadR(loadR),
    .loadIp(loadIp), .loadOpnd(loadOpnd), .loadDout(loadDout), .loadIr(loadIr),
    .loadDin(loadDin), .loadAr(loadAr), .arFromOpnd(arFromOpnd), .ipInc(ipInc),
    .ipClr(ipClr), .irClr(irClr), .memWr(memWr), .ioWr(ioWr),
    .aluResult(aluResult), .extDataIn(extDataIn), .accOut(accOut),
    .busOut(busOut), .rMon(rMon), .irOut(irOut), .extAddr(extAddr),
    .extDataOut(extDataOut), .extDataOe(extDataOe)
  );

  localparam logic [4:0] S_NO = 5'b00000, S_ACC = 5'b00001, S_R = 5'b00010;
  localparam logic [4:0] S_IP = 5'b00100, S_OP = 5'b01000, S_DIN = 5'b10000;
  localparam logic [7:0] L_0 = 8'h00, L_ACC = 8'h80, L_R = 8'h40, L_IP = 8'h20;
  localparam logic [7:0] L_OP = 8'h10, L_DO = 8'h08, L_IR = 8'h04, L_DIN = 8'h02, L_AR = 8'h01;
  localparam logic [5:0] M_0 = 6'h00, M_AROP = 6'h20, M_INC = 6'h10, M_CLR = 6'h08;
  localparam logic [5:0] M_IRCLR = 6'h04, M_MW = 6'h02, M_IW = 6'h01;

  // row: sel, loads, misc, alu, din, expBus, expAcc, expAddr, expIr
  localparam int NROW = 12;
  localparam logic [66:0] TBL [NROW] = '{
    {S_NO,  L_DIN,      M_0,           8'h00, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00},
    {S_DIN, L_IR,       M_0,           8'h00, 8'h3C, 8'h3C, 8'h00, 8'h00, 8'h3C},
    {S_DIN, L_R | L_ACC, M_0,          8'h5A, 8'h3C, 8'h3C, 8'h5A, 8'h00, 8'h3C},
    {S_R,   L_OP,       M_INC,         8'h00, 8'h00, 8'h3C, 8'h5A, 8'h00, 8'h3C},
    {S_NO,  L_AR,       M_AROP,        8'h00, 8'h00, 8'h00, 8'h5A, 8'h3C, 8'h3C},
    {S_IP,  L_AR,       M_INC,         8'h00, 8'h00, 8'h01, 8'h5A, 8'h01, 8'h3C},
    {S_ACC, L_DO,       M_0,           8'h77, 8'h00, 8'h5A, 8'h5A, 8'h01, 8'h3C},
    {S_ACC, L_IP,       M_0,           8'h00, 8'h00, 8'h5A, 8'h5A, 8'h01, 8'h3C},
    {S_IP,  L_AR,       M_0,           8'h00, 8'h00, 8'h5A, 8'h5A, 8'h5A, 8'h3C},
    {S_DIN, L_IR,       M_IRCLR,       8'h00, 8'h00, 8'h3C, 8'h5A, 8'h5A, 8'h00},
    {S_OP,  L_IP,       M_CLR | M_INC, 8'h00, 8'h00, 8'h3C, 8'h5A, 8'h5A, 8'h00},
    {S_IP,  L_AR,       M_0,           8'h00, 8'h00, 8'h00, 8'h5A, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] sel, input logic [7:0] ld, input logic [5:0] misc,
                       input logic [7:0] alu, input logic [7:0] din);
    @(negedge clk);
    busSel = sel;
    {loadAcc, loadR, loadIp, loadOpnd, loadDout, loadIr, loadDin, loadAr} = ld;
    {arFromOpnd, ipInc, ipClr, irClr, memWr, ioWr} = misc;
    aluResult = alu;
    extDataIn = din;
  endtask

  task automatic edgeThen;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 acc", accOut, 8'h00);
    chk("R1 addr", extAddr, 8'h00);
    chk("R1 ir", irOut, 8'h00);
    chk("R1 bus", busOut, 8'h00);
    chk("R1 rMon", rMon, 8'h00);
    chk("R1 dataOut", extDataOut, 8'h00);
    chk("R1 oe", {7'd0, extDataOe}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      logic [66:0] row;
      row = TBL[i];
      drive(row[66:62], row[61:54], row[53:48], row[47:40], row[39:32]);
      #1;
      chk($sformatf("R2 bus row %0d", i), busOut, row[31:24]);
      edgeThen();
      chk($sformatf("R4 acc row %0d", i), accOut, row[23:16]);
      chk($sformatf("R6 addr row %0d", i), extAddr, row[15:8]);
      chk($sformatf("R5/R8 ir row %0d", i), irOut, row[7:0]);
    end
    // state: A=5A R=3C IP=00 OR=3C AR=00 IR=00 DIN=3C DOUT=5A

    // R3 and R5 monitor
    drive(S_R, L_0, M_0, 8'hEE, 8'h00);
    #1;
    chk("R3 acc while R on bus", accOut, 8'h5A);
    chk("R5 bus carries R", busOut, 8'h3C);
    chk("R5 rMon", rMon, 8'h3C);

    // R10 write gating
    drive(S_NO, L_0, M_MW, 8'h00, 8'h00);
    #1;
    chk("R10 memWr data", extDataOut, 8'h5A);
    chk("R10 memWr oe", {7'd0, extDataOe}, 8'h01);
    drive(S_NO, L_0, M_IW, 8'h00, 8'h00);
    #1;
    chk("R10 ioWr data", extDataOut, 8'h5A);
    drive(S_NO, L_0, M_0, 8'h00, 8'h00);
    #1;
    chk("R10 idle data", extDataOut, 8'h00);
    chk("R10 idle oe", {7'd0, extDataOe}, 8'h00);

    // R9 capture only with strobe
    drive(S_DIN, L_0, M_0, 8'h00, 8'h99);
    edgeThen();
    chk("R9 no capture", busOut, 8'h3C);
    drive(S_DIN, L_DIN, M_0, 8'h00, 8'h99);
    edgeThen();
    chk("R9 capture", busOut, 8'h99);

    // R7 wrap and priority
    drive(S_NO, L_DIN, M_0, 8'h00, 8'hFF);
    drive(S_DIN, L_IP, M_0, 8'h00, 8'h00);
    drive(S_NO, L_0, M_INC, 8'h00, 8'h00);
    drive(S_IP, L_0, M_0, 8'h00, 8'h00);
    #1;
    chk("R7 wrap FF to 00", busOut, 8'h00);
    drive(S_DIN, L_IP, M_INC, 8'h00, 8'h00);
    drive(S_IP, L_0, M_0, 8'h00, 8'h00);
    #1;
    chk("R7 load beats inc", busOut, 8'hFF);

    // R11 indirect chain
    drive(S_NO, L_DIN, M_0, 8'h00, 8'h42);
    drive(S_DIN, L_R, M_0, 8'h00, 8'h00);
    drive(S_R, L_OP, M_0, 8'h00, 8'h00);
    edgeThen();
    chk("R11 addr before move", extAddr, 8'h00);
    drive(S_NO, L_AR, M_AROP, 8'h00, 8'h00);
    edgeThen();
    chk("R11 indirect addr", extAddr, 8'h42);

    finished = 1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule